// File: doc/BRIEF.md
# Routed Interrupt Controller

The block gathers 32 raw interrupt inputs and turns each one into a pending bit. Each source is conditioned on its own: a two-flop synchronizer, then either a level qualifier or an edge catcher, with a polarity bit that chooses the active level or the active edge. Software masks sources through a set-only port and a clear-only port. It can read back the pending bits, the enable mask, the polarity bits and the mode bits. Edge sources stay pending until software clears them by writing a one.

Every source owns a routing byte. The low nibble is a one-hot core selector and the high nibble is a one-hot line selector. The 16 outputs form a 4x4 grid of core by line. A grid point is high while any source that is both pending and enabled has its core bit and its line bit set. Software finds the work to do by ANDing the pending word with the enable word.

The register port is synchronous and word addressed. A write takes effect at the clock edge on which it is presented. Read data is registered and appears one cycle after the read.

Top module: `intc_router`

## Requirements
- R1: After reset, the enable, polarity and mode words read 0. Every routing byte reads 0x11. All 16 outputs are low.
- R2: A write to word 10 sets the enable bits where the data has a one and leaves the other bits alone. Word 9 reads back the enable mask.
- R3: A write to word 11 clears the enable bits where the data has a one and leaves the other bits alone.
- R4: With mode bit 0 (level), pending bit s reads 1 when input s equals polarity bit s. A write of ones to the pending word (word 8) does not change it.
- R5: With mode bit 1 (edge), a rising edge (polarity 1) or a falling edge (polarity 0) of input s sets pending bit s. The bit stays set until a one is written to bit s of word 8. Zero bits in that write have no effect. An edge that arrives in the same cycle as the clear wins over the clear.
- R6: A change on an input shows on the pending bit and on the outputs after the third rising clock edge that follows it, not before.
- R7: Output index c*4+l is high exactly when some source is pending, is enabled, and has bit c and bit 4+l set in its routing byte.
- R8: Words 0 to 7 hold the routing bytes. Word k carries source 4k+j in bits [8j+7:8j]. These bytes can be read back.
- R9: Words 12 (polarity) and 14 (mode) read back what was written. Words 10, 11, 13 and 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_raw_i | input | 32 | Raw interrupt inputs, asynchronous |
| irq_o | output | 16 | Routed outputs, index core*4+line |

## Verification
A corrupted enable bit, polarity bit or mode bit shows in the register readback on the very next read. It also shows on the output grid about three cycles after the source moves. A pending bit that is latched wrongly, or cleared wrongly, shows one cycle after the offending edge or write, both in the pending word and on its routed output. A routing byte that decodes wrongly lights the wrong grid point. Driving one source at a time into a distinct core and line pair makes that visible after the synchronizer delay.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC   = 32;
    localparam int NCORE  = 4;
    localparam int NLINE  = 4;
    localparam int RW     = NCORE + NLINE;
    localparam int NOUT   = NCORE * NLINE;
    localparam int DW     = NSRC;
    localparam int BPW    = DW / RW;
    localparam int LBW    = $clog2(BPW);
    localparam int RWORDS = NSRC / BPW;
    localparam int RWB    = $clog2(RWORDS);
    localparam int AW     = RWB + 1;

    localparam logic [AW-1:0] W_STAT  = AW'(RWORDS + 0);
    localparam logic [AW-1:0] W_ENST  = AW'(RWORDS + 1);
    localparam logic [AW-1:0] W_EN    = AW'(RWORDS + 2);
    localparam logic [AW-1:0] W_DIS   = AW'(RWORDS + 3);
    localparam logic [AW-1:0] W_POL   = AW'(RWORDS + 4);
    localparam logic [AW-1:0] W_MODE  = AW'(RWORDS + 6);

    localparam logic [RW-1:0] ROUTE_RST = RW'(8'h11);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic stat;
    } cond_t;

    typedef struct packed {
        logic [NSRC-1:0]          en;
        logic [NSRC-1:0]          pol;
        logic [NSRC-1:0]          mode;
        logic [DW-1:0]            rdata;
        logic [NSRC-1:0][RW-1:0]  route;
    } regs_t;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic pol_i,
    input  logic mode_i,
    input  logic clr_i,
    output logic stat_o,
    output logic hit_o
);
    cond_t c_d, c_q;
    logic  level;
    logic  hit;

    always_comb begin
        c_d      = c_q;
        c_d.s1   = raw_i;
        c_d.s2   = c_q.s1;
        c_d.prev = c_q.s2;
        level    = pol_i ? c_q.s2 : ~c_q.s2;
        if (mode_i) begin
            hit = pol_i ? (c_q.s2 & ~c_q.prev) : (~c_q.s2 & c_q.prev);
        end else begin
            hit = 1'b0;
        end
        if (mode_i) begin
            c_d.stat = hit | (c_q.stat & ~clr_i);
        end else begin
            c_d.stat = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign stat_o = c_q.stat;
    assign hit_o  = hit;
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_i,
    input  logic                     wr_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic [NSRC-1:0]          stat_i,
    output logic [DW-1:0]            rdata_o,
    output logic [NSRC-1:0]          en_o,
    output logic [NSRC-1:0]          pol_o,
    output logic [NSRC-1:0]          mode_o,
    output logic [NSRC-1:0]          clr_o,
    output logic [NSRC-1:0][RW-1:0]  route_o
);
    regs_t r_d, r_q;
    logic  wsel, rsel, in_route;

    always_comb begin
        r_d      = r_q;
        clr_o    = '0;
        wsel     = sel_i & wr_i;
        rsel     = sel_i & ~wr_i;
        in_route = ~addr_i[AW-1];

        if (wsel) begin
            if (in_route) begin
                for (int j = 0; j < BPW; j++) begin
                    r_d.route[{addr_i[RWB-1:0], LBW'(j)}] = wdata_i[j*RW +: RW];
                end
            end else begin
                case (addr_i)
                    W_STAT:  clr_o      = wdata_i;
                    W_EN:    r_d.en     = r_q.en | wdata_i;
                    W_DIS:   r_d.en     = r_q.en & ~wdata_i;
                    W_POL:   r_d.pol    = wdata_i;
                    W_MODE:  r_d.mode   = wdata_i;
                    default: ;
                endcase
            end
        end

        if (rsel) begin
            r_d.rdata = '0;
            if (in_route) begin
                for (int j = 0; j < BPW; j++) begin
                    r_d.rdata[j*RW +: RW] = r_q.route[{addr_i[RWB-1:0], LBW'(j)}];
                end
            end else begin
                case (addr_i)
                    W_STAT:  r_d.rdata = stat_i;
                    W_ENST:  r_d.rdata = r_q.en;
                    W_POL:   r_d.rdata = r_q.pol;
                    W_MODE:  r_d.rdata = r_q.mode;
                    default: r_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.route <= {NSRC{ROUTE_RST}};
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata_o = r_q.rdata;
    assign en_o    = r_q.en;
    assign pol_o   = r_q.pol;
    assign mode_o  = r_q.mode;
    assign route_o = r_q.route;
endmodule

// File: rtl/intc_route_mux.sv
module intc_route_mux
    import intc_pkg::*;
(
    input  logic [NSRC-1:0]          pend_i,
    input  logic [NSRC-1:0][RW-1:0]  route_i,
    output logic [NOUT-1:0]          irq_o
);
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        for (genvar l = 0; l < NLINE; l++) begin : g_line
            logic [NSRC-1:0] hits;
            always_comb begin
                for (int s = 0; s < NSRC; s++) begin
                    hits[s] = pend_i[s] & route_i[s][c] & route_i[s][NCORE+l];
                end
            end
            assign irq_o[c*NLINE+l] = |hits;
        end
    end
endmodule

// File: rtl/intc_router.sv
module intc_router
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [NSRC-1:0]   irq_raw_i,
    output logic [NOUT-1:0]   irq_o
);
    logic [NSRC-1:0]          en_vec, pol_vec, mode_vec, clr_vec;
    logic [NSRC-1:0]          stat_vec, hit_vec, pend_vec;
    logic [NSRC-1:0][RW-1:0]  route_vec;

    intc_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .stat_i  (stat_vec),
        .rdata_o (rdata_o),
        .en_o    (en_vec),
        .pol_o   (pol_vec),
        .mode_o  (mode_vec),
        .clr_o   (clr_vec),
        .route_o (route_vec)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        intc_src_cond i_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (irq_raw_i[s]),
            .pol_i  (pol_vec[s]),
            .mode_i (mode_vec[s]),
            .clr_i  (clr_vec[s]),
            .stat_o (stat_vec[s]),
            .hit_o  (hit_vec[s])
        );
    end

    assign pend_vec = stat_vec & en_vec;

    intc_route_mux i_mux (
        .pend_i  (pend_vec),
        .route_i (route_vec),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/intc_router_chk.sv
module intc_router_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic              wr_i,
    input logic [AW-1:0]     addr_i,
    input logic [DW-1:0]     wdata_i,
    input logic [NSRC-1:0]   en_vec,
    input logic [NSRC-1:0]   stat_vec,
    input logic [NSRC-1:0]   mode_vec,
    input logic [NSRC-1:0]   hit_vec,
    input logic [NOUT-1:0]   irq_o
);
    logic wr_en, wr_dis, wr_stat;
    assign wr_en   = sel_i & wr_i & (addr_i == W_EN);
    assign wr_dis  = sel_i & wr_i & (addr_i == W_DIS);
    assign wr_stat = sel_i & wr_i & (addr_i == W_STAT);

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((en_vec & $past(wdata_i)) == $past(wdata_i))); // R2
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || wr_dis) |=> $stable(en_vec)); // R2
    AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis |=> ((en_vec & $past(wdata_i)) == '0)); // R3
    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_vec & $past(wdata_i) & $past(mode_vec) & ~$past(hit_vec)) == '0)); // R5
    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |=> ((stat_vec & $past(hit_vec)) == $past(hit_vec))); // R5
    AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> (irq_o == '0)); // R7
endmodule

bind intc_router intc_router_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .en_vec   (en_vec),
    .stat_vec (stat_vec),
    .mode_vec (mode_vec),
    .hit_vec  (hit_vec),
    .irq_o    (irq_o)
);

// File: tb/test_intc_router.sv
module test_intc_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [31:0] irq_raw_i = '0;
    logic [15:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] route_m [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_router i_intc_router (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_raw_i(irq_raw_i), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        sel_i = 1'b0; wr_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
        @(negedge clk);
        sel_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] rbyte(input int s);
        return 8'((1 << (s % 4)) | (1 << (4 + (s / 4) % 4)));
    endfunction

    function automatic logic [15:0] exp_irq(input logic [31:0] pend);
        logic [15:0] e = '0;
        for (int s = 0; s < 32; s++)
            if (pend[s])
                for (int c = 0; c < 4; c++)
                    for (int l = 0; l < 4; l++)
                        if (route_m[s][c] && route_m[s][4+l]) e[c*4+l] = 1'b1;
        return e;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, p, pol;
        for (int s = 0; s < 32; s++) route_m[s] = 8'h11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int k = 0; k < 8; k++) begin
            rd(4'(k), d); chk("R1 route reset", d, 32'h1111_1111);
        end
        rd(4'd9, d);  chk("R1 enable reset", d, 32'h0);
        rd(4'd12, d); chk("R1 polarity reset", d, 32'h0);
        rd(4'd14, d); chk("R1 mode reset", d, 32'h0);
        chk("R1 outputs low", 32'(irq_o), 32'h0);

        // R8 routing bytes
        for (int s = 0; s < 32; s++) route_m[s] = rbyte(s);
        for (int k = 0; k < 8; k++)
            wr(4'(k), {route_m[4*k+3], route_m[4*k+2], route_m[4*k+1], route_m[4*k]});
        for (int k = 0; k < 8; k++) begin
            rd(4'(k), d);
            chk("R8 route readback", d, {route_m[4*k+3], route_m[4*k+2], route_m[4*k+1], route_m[4*k]});
        end

        // R2 / R3 enable set and clear
        wr(4'd10, 32'h0000_00FF); rd(4'd9, d); chk("R2 enable set", d, 32'h0000_00FF);
        wr(4'd10, 32'h0F00_0000); rd(4'd9, d); chk("R2 enable accumulate", d, 32'h0F00_00FF);
        wr(4'd11, 32'h0000_000F); rd(4'd9, d); chk("R3 disable partial", d, 32'h0F00_00F0);
        wr(4'd11, 32'hFFFF_FFFF); rd(4'd9, d); chk("R3 disable all", d, 32'h0);

        // R9 readback and zero words
        wr(4'd12, 32'hA5A5_5A5A); rd(4'd12, d); chk("R9 polarity readback", d, 32'hA5A5_5A5A);
        wr(4'd14, 32'h3C3C_C3C3); rd(4'd14, d); chk("R9 mode readback", d, 32'h3C3C_C3C3);
        wr(4'd14, 32'h0);
        rd(4'd10, d); chk("R9 enable port reads 0", d, 32'h0);
        rd(4'd11, d); chk("R9 disable port reads 0", d, 32'h0);
        rd(4'd13, d); chk("R9 reserved 13 reads 0", d, 32'h0);
        rd(4'd15, d); chk("R9 reserved 15 reads 0", d, 32'h0);

        // R4 level sources of both polarities
        pol = 32'hFFFF_0000;
        wr(4'd12, pol);
        for (int i = 0; i < 4; i++) begin
            p = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : (i == 2) ? 32'h1234_5678 : 32'hA5A5_0F0F;
            irq_raw_i = p;
            settle();
            rd(4'd8, d); chk("R4 level status", d, ~(p ^ pol));
            wr(4'd8, 32'hFFFF_FFFF);
            rd(4'd8, d); chk("R4 level not clearable", d, ~(p ^ pol));
        end

        // R6 synchronizer latency, source 0 active-high level
        wr(4'd12, 32'hFFFF_FFFF);
        irq_raw_i = 32'h0;
        wr(4'd10, 32'h1);
        settle();
        chk("R6 idle before change", 32'(irq_o), 32'h0);
        @(negedge clk); irq_raw_i = 32'h1;
        repeat (2) @(posedge clk);
        @(negedge clk); chk("R6 not yet after two edges", 32'(irq_o), 32'h0);
        @(posedge clk);
        @(negedge clk); chk("R6 visible after third edge", 32'(irq_o), 32'h1);
        irq_raw_i = 32'h0;
        wr(4'd11, 32'hFFFF_FFFF);
        settle();

        // R5 edge capture, rising low half and falling high half
        wr(4'd12, 32'h0000_FFFF);
        wr(4'd14, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, d); chk("R5 cleared", d, 32'h0);
        irq_raw_i = 32'hFFFF_FFFF; settle();
        rd(4'd8, d); chk("R5 rising captured", d, 32'h0000_FFFF);
        irq_raw_i = 32'h0; settle();
        rd(4'd8, d); chk("R5 falling captured", d, 32'hFFFF_FFFF);
        wr(4'd8, 32'h0000_00FF);
        rd(4'd8, d); chk("R5 partial clear", d, 32'hFFFF_FF00);
        wr(4'd8, 32'h0);
        rd(4'd8, d); chk("R5 zero write no effect", d, 32'hFFFF_FF00);

        // R5 per-source rising sweep
        wr(4'd12, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        for (int s = 0; s < 32; s++) begin
            irq_raw_i = 32'(1) << s; settle();
            rd(4'd8, d); chk("R5 sweep rise", d, 32'(1) << s);
            irq_raw_i = 32'h0; settle();
            rd(4'd8, d); chk("R5 sweep hold on fall", d, 32'(1) << s);
            wr(4'd8, 32'(1) << s);
            rd(4'd8, d); chk("R5 sweep clear", d, 32'h0);
        end

        // R7 routing per source, active-high level
        wr(4'd14, 32'h0);
        wr(4'd10, 32'hFFFF_FFFF);
        for (int s = 0; s < 32; s++) begin
            irq_raw_i = 32'(1) << s; settle();
            chk("R7 single source route", 32'(irq_o), 32'(exp_irq(32'(1) << s)));
            wr(4'd11, 32'(1) << s);
            chk("R7 masked source silent", 32'(irq_o), 32'h0);
            wr(4'd10, 32'(1) << s);
        end
        irq_raw_i = 32'hFFFF_FFFF; settle();
        chk("R7 all sources", 32'(irq_o), 32'(exp_irq(32'hFFFF_FFFF)));
        wr(4'd0, 32'h1111_11FF); route_m[0] = 8'hFF; route_m[1] = 8'h11;
        route_m[2] = 8'h11; route_m[3] = 8'h11;
        irq_raw_i = 32'h1; settle();
        chk("R7 multi-bit route", 32'(irq_o), 32'(exp_irq(32'h1)));

        finish_run();
    end
endmodule